// File: doc/BRIEF.md
# Bidirectional Multi-Ring Data Transfer Arbiter

This block decides which pending point-to-point data transfer may start next on a set of unidirectional data rings. Twelve bus ports sit on every ring. Four rings are built, each 16 bytes wide. Rings 0 and 1 move data toward the next-higher port index, wrapping from port 11 to port 0. Rings 2 and 3 move data toward the next-lower index. A ring segment k is the link between port k and port (k+1) mod 12. A transfer from a source to a destination occupies every segment it crosses in its ring's direction.

Each port requests with its own valid bit and a destination index; the source is the port's own position. Arbitration runs in two round-robin stages. The first stage picks one port among those whose transfer could be placed right now. The second stage picks a ring within the chosen direction. A granted transfer keeps its segments reserved until the port pulses its release line. Ports never see ring numbers in their data path. The ring number is reported only so that the datapath can be steered.

Top module: `ring_data_arb`

## Requirements
- R1: After reset no grant and no error is asserted, every ring is empty, and both round-robin stages start from port 0, ring 0 (upward) and ring 2 (downward).
- R2: At most one port is granted per cycle; `gnt[p]` is a one-cycle pulse in the cycle after a clock edge at which `req_vld[p]` was high.
- R3: A transfer is placed in the direction with fewer hops, where upward hops = (dst-src) mod 12 and downward hops = (src-dst) mod 12; a tie goes upward. `gnt_ring[2p+1:2p]` holds the ring number (0,1 upward; 2,3 downward) of port p's latest grant.
- R4: Two transfers held on the same ring never share a segment; when neither ring of the preferred direction can take the path, the transfer is placed in the other direction.
- R5: No ring holds more than three transfers at once; a fourth transfer that would fit on its segments goes to another ring.
- R6: A port holding a transfer is not granted again until it pulses `rel[p]`; the release frees that transfer's segments, and the port can be granted at the second clock edge after the release was sampled at the earliest.
- R7: A request with dst equal to its own port index or dst of 12 or more raises `req_err[p]` in the next cycle and is never granted.
- R8: Among ports that can be placed, the search starts at the port after the last granted one and wraps at 11.
- R9: Within one direction the ring choice rotates: the search starts at the ring after the one last used in that direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | 12 | Per-port transfer request, held until granted |
| req_dst | input | 48 | Per-port destination index, 4 bits per port, port p at [4p+3:4p] |
| rel | input | 12 | Per-port pulse ending the port's outstanding transfer |
| gnt | output | 12 | Per-port grant pulse |
| gnt_ring | output | 24 | Per-port ring number of the latest grant, 2 bits per port |
| req_err | output | 12 | Per-port flag for a request with an invalid destination |

## Verification
Single transfers on an idle ring set, with the hop count below, above and equal to half the ring, separate the direction choice from the ring rotation. A stack of overlapping upward paths forces a downward fallback. Six short disjoint paths fill both upward rings to their limit, which separates the segment check from the per-ring count. Three simultaneous requests starting away from port 0 show where the port search begins. A held request from a busy port shows that reservations last until release and no longer. Self-addressed and out-of-range destinations check the error path.

// File: rtl/ring_arb_pkg.sv
// Shared types for the multi-ring data arbiter.
package ring_arb_pkg;
    // Travel direction of a ring relative to increasing port index.
    typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} ring_dir_e;
endpackage

// File: rtl/rr_pick.sv
// Round-robin picker: returns the first set request at or after ptr, wrapping.
// Assumes ptr < W. Purely combinational.
module rr_pick #(
    parameter int W = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the pointer position and keep the first hit.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            int k;
            k = (int'(ptr) + i) % W;
            if (!any && req[k]) begin
                any = 1'b1;
                idx = IW'(k);
            end
        end
    end
endmodule

// File: rtl/ring_fit.sv
// Path and placement check for one source port.
// Computes the segment masks of both directions toward dst and which rings can
// take the transfer now. Assumes segment k joins port k and port k+1 mod N.
module ring_fit #(
    parameter int N_PORTS = 12,
    parameter int N_RINGS = 4,
    parameter int SRC     = 0,
    localparam int PW   = $clog2(N_PORTS),
    localparam int HALF = N_RINGS / 2
) (
    input  logic [PW-1:0]              dst,
    input  logic [N_RINGS*N_PORTS-1:0] occ,
    input  logic [N_RINGS-1:0]         ring_open,
    output logic                       bad,
    output logic                       pref_up,
    output logic [HALF-1:0]            fit_up,
    output logic [HALF-1:0]            fit_dn,
    output logic [N_PORTS-1:0]         path_up,
    output logic [N_PORTS-1:0]         path_dn
);
    // Hop counts, preferred direction and segment masks of both paths.
    always_comb begin
        int d, hu, hd;
        d       = int'(dst);
        bad     = (d == SRC) || (d >= N_PORTS);
        hu      = (d - SRC + N_PORTS) % N_PORTS;
        hd      = (SRC - d + N_PORTS) % N_PORTS;
        pref_up = (hu <= hd);
        for (int j = 0; j < N_PORTS; j++) begin
            path_up[j] = ((j - SRC + N_PORTS) % N_PORTS) < hu;
            path_dn[j] = ((SRC - 1 - j + 2 * N_PORTS) % N_PORTS) < hd;
        end
    end

    // A ring fits when it has room and none of the path's segments is held.
    for (genvar k = 0; k < HALF; k++) begin : g_fit
        assign fit_up[k] = !bad && ring_open[k] &&
                           ((occ[k*N_PORTS +: N_PORTS] & path_up) == '0);
        assign fit_dn[k] = !bad && ring_open[HALF+k] &&
                           ((occ[(HALF+k)*N_PORTS +: N_PORTS] & path_dn) == '0);
    end
endmodule

// File: rtl/ring_data_arb.sv
// Two-stage round-robin arbiter for data transfers on bidirectional rings.
// Stage 1 picks one placeable port, stage 2 a ring in the chosen direction.
// Rings [0, N_RINGS/2) run upward, the rest downward. One grant per cycle.
// Assumes a port holds req_vld until granted and pulses rel only while busy.
module ring_data_arb
    import ring_arb_pkg::*;
#(
    parameter int N_PORTS  = 12,
    parameter int N_RINGS  = 4,
    parameter int MAX_XFER = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [N_PORTS-1:0]                     req_vld,
    input  logic [N_PORTS*$clog2(N_PORTS)-1:0]     req_dst,
    input  logic [N_PORTS-1:0]                     rel,
    output logic [N_PORTS-1:0]                     gnt,
    output logic [N_PORTS*$clog2(N_RINGS)-1:0]     gnt_ring,
    output logic [N_PORTS-1:0]                     req_err
);
    localparam int PW   = $clog2(N_PORTS);
    localparam int RW   = $clog2(N_RINGS);
    localparam int HALF = N_RINGS / 2;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int CW   = $clog2(MAX_XFER + 1);

    logic [N_RINGS-1:0][N_PORTS-1:0] occ_q, occ_d;
    logic [N_RINGS-1:0][CW-1:0]      cnt_q, cnt_d;
    logic [N_RINGS-1:0]              ring_open;
    logic [N_PORTS-1:0]              busy_q;
    logic [N_PORTS-1:0][RW-1:0]      own_ring_q;
    logic [N_PORTS-1:0][N_PORTS-1:0] own_path_q;
    logic [PW-1:0]                   port_ptr_q;
    logic [1:0][HW-1:0]              dir_ptr_q;
    logic [N_PORTS-1:0]              gnt_q, err_q;

    logic [N_PORTS-1:0]              bad_v, pref_v, eligible;
    logic [N_PORTS-1:0][HALF-1:0]    fup, fdn;
    logic [N_PORTS-1:0][N_PORTS-1:0] pup, pdn;

    // Ring room flags from the per-ring transfer count.
    for (genvar r = 0; r < N_RINGS; r++) begin : g_open
        assign ring_open[r] = (cnt_q[r] < CW'(MAX_XFER));
    end

    // Per-port path computation and placement check.
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        ring_fit #(.N_PORTS(N_PORTS), .N_RINGS(N_RINGS), .SRC(p)) u_fit (
            .dst      (req_dst[p*PW +: PW]),
            .occ      (occ_q),
            .ring_open(ring_open),
            .bad      (bad_v[p]),
            .pref_up  (pref_v[p]),
            .fit_up   (fup[p]),
            .fit_dn   (fdn[p]),
            .path_up  (pup[p]),
            .path_dn  (pdn[p])
        );
        assign eligible[p] = req_vld[p] && !busy_q[p] && !bad_v[p] &&
                             ((|fup[p]) || (|fdn[p]));
    end

    // Stage 1: round-robin over placeable ports.
    logic          p_any;
    logic [PW-1:0] pw;
    rr_pick #(.W(N_PORTS)) u_port_pick (
        .req(eligible), .ptr(port_ptr_q), .any(p_any), .idx(pw)
    );

    // Direction choice for the stage-1 winner: preferred unless blocked.
    logic            go_up;
    ring_dir_e       win_dir;
    logic [HALF-1:0] cand;
    logic [HW-1:0]   dsel_ptr;
    logic [N_PORTS-1:0] win_path;
    always_comb begin
        go_up    = pref_v[pw] ? (|fup[pw]) : !(|fdn[pw]);
        win_dir  = go_up ? DIR_UP : DIR_DOWN;
        cand     = go_up ? fup[pw] : fdn[pw];
        win_path = go_up ? pup[pw] : pdn[pw];
        dsel_ptr = go_up ? dir_ptr_q[0] : dir_ptr_q[1];
    end

    // Stage 2: round-robin over fitting rings of the chosen direction.
    logic          r_any;
    logic [HW-1:0] rloc;
    rr_pick #(.W(HALF)) u_ring_pick (
        .req(cand), .ptr(dsel_ptr), .any(r_any), .idx(rloc)
    );

    logic          do_grant;
    logic [RW-1:0] win_ring;
    assign do_grant = p_any && r_any;
    assign win_ring = (win_dir == DIR_UP) ? RW'(rloc) : RW'(HALF) + RW'(rloc);

    // Next occupancy and counts: releases first, then the new reservation.
    always_comb begin
        occ_d = occ_q;
        cnt_d = cnt_q;
        for (int p = 0; p < N_PORTS; p++) begin
            if (rel[p] && busy_q[p]) begin
                occ_d[own_ring_q[p]] = occ_d[own_ring_q[p]] & ~own_path_q[p];
                cnt_d[own_ring_q[p]] = cnt_d[own_ring_q[p]] - 1'b1;
            end
        end
        if (do_grant) begin
            occ_d[win_ring] = occ_d[win_ring] | win_path;
            cnt_d[win_ring] = cnt_d[win_ring] + 1'b1;
        end
    end

    // State, pointers and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q      <= '0;
            cnt_q      <= '0;
            busy_q     <= '0;
            own_ring_q <= '0;
            own_path_q <= '0;
            port_ptr_q <= '0;
            dir_ptr_q  <= '0;
            gnt_q      <= '0;
            err_q      <= '0;
        end else begin
            occ_q <= occ_d;
            cnt_q <= cnt_d;
            gnt_q <= '0;
            err_q <= req_vld & bad_v;
            for (int p = 0; p < N_PORTS; p++) begin
                if (rel[p] && busy_q[p]) busy_q[p] <= 1'b0;
            end
            if (do_grant) begin
                busy_q[pw]     <= 1'b1;
                own_ring_q[pw] <= win_ring;
                own_path_q[pw] <= win_path;
                gnt_q[pw]      <= 1'b1;
                port_ptr_q     <= (pw == PW'(N_PORTS - 1)) ? '0 : pw + 1'b1;
                if (win_dir == DIR_UP)
                    dir_ptr_q[0] <= (rloc == HW'(HALF - 1)) ? '0 : rloc + 1'b1;
                else
                    dir_ptr_q[1] <= (rloc == HW'(HALF - 1)) ? '0 : rloc + 1'b1;
            end
        end
    end

    assign gnt      = gnt_q;
    assign req_err  = err_q;
    assign gnt_ring = own_ring_q;
endmodule

// File: rtl/ring_data_arb_chk.sv
// Protocol checker for ring_data_arb, built only from its ports.
// Tracks which ports hold a transfer and how many transfers each ring carries.
module ring_data_arb_chk #(
    parameter int N_PORTS  = 12,
    parameter int N_RINGS  = 4,
    parameter int MAX_XFER = 3,
    localparam int PW = $clog2(N_PORTS),
    localparam int RW = $clog2(N_RINGS),
    localparam int LW = $clog2(N_PORTS + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_PORTS-1:0]    req_vld,
    input logic [N_PORTS*PW-1:0] req_dst,
    input logic [N_PORTS-1:0]    rel,
    input logic [N_PORTS-1:0]    gnt,
    input logic [N_PORTS*RW-1:0] gnt_ring,
    input logic [N_PORTS-1:0]    req_err
);
    logic [N_PORTS-1:0]         held_q;
    logic [N_RINGS-1:0][LW-1:0] live_q, live_d;

    // Per-ring live transfer count seen at the ports.
    always_comb begin
        live_d = live_q;
        for (int p = 0; p < N_PORTS; p++) begin
            if (rel[p] && held_q[p])
                live_d[gnt_ring[p*RW +: RW]] = live_d[gnt_ring[p*RW +: RW]] - 1'b1;
            if (gnt[p])
                live_d[gnt_ring[p*RW +: RW]] = live_d[gnt_ring[p*RW +: RW]] + 1'b1;
        end
    end

    // Held-transfer flags and counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            live_q <= '0;
        end else begin
            live_q <= live_d;
            for (int p = 0; p < N_PORTS; p++) begin
                if (rel[p] && held_q[p]) held_q[p] <= 1'b0;
                if (gnt[p]) held_q[p] <= 1'b1;
            end
        end
    end

    // R2: never more than one grant in a cycle.
    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port_chk
        // R2: a grant follows a sampled request.
        a_r2_grant_after_req: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[p] |-> $past(req_vld[p]));
        // R6: no second grant while a transfer is held.
        a_r6_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[p] |-> !held_q[p]);
        // R7: an invalid destination is flagged and never granted.
        a_r7_bad_flagged: assert property (@(posedge clk) disable iff (!rst_n)
            (req_vld[p] && ((int'(req_dst[p*PW +: PW]) == p) ||
                            (int'(req_dst[p*PW +: PW]) >= N_PORTS)))
            |=> (req_err[p] && !gnt[p]));
    end

    for (genvar r = 0; r < N_RINGS; r++) begin : g_ring_chk
        // R5: ring capacity limit.
        a_r5_ring_cap: assert property (@(posedge clk) disable iff (!rst_n)
            live_q[r] <= LW'(MAX_XFER));
    end
endmodule

bind ring_data_arb ring_data_arb_chk #(
    .N_PORTS(N_PORTS), .N_RINGS(N_RINGS), .MAX_XFER(MAX_XFER)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_dst(req_dst),
    .rel(rel), .gnt(gnt), .gnt_ring(gnt_ring), .req_err(req_err)
);

// File: tb/test_ring_data_arb.sv
// Self-checking bench: table of single transfers, then directed cases.
module test_ring_data_arb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] req_vld = '0;
    logic [4*NP-1:0] req_dst = '0;
    logic [NP-1:0] rel = '0;
    logic [NP-1:0] gnt;
    logic [2*NP-1:0] gnt_ring;
    logic [NP-1:0] req_err;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Table rows: source, destination, expected ring (idle rings, no release
    // overlap). Exercises R3 direction choice and R9 ring rotation.
    localparam int TBL[8][3] = '{
        '{0, 3, 0}, '{5, 2, 2}, '{4, 10, 1}, '{11, 1, 0},
        '{1, 11, 3}, '{7, 8, 1}, '{8, 7, 2}, '{0, 11, 3}
    };

    ring_data_arb i_ring_data_arb (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_dst(req_dst),
        .rel(rel), .gnt(gnt), .gnt_ring(gnt_ring), .req_err(req_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic ask(input int p, input int d);
        req_vld[p] = 1'b1;
        req_dst[p*4 +: 4] = 4'(d);
    endtask

    // Request one transfer, check its grant and ring one cycle later.
    task automatic one(input int s, input int d, input int ring, input string tag);
        @(negedge clk);
        ask(s, d);
        @(negedge clk);
        check({tag, " grant"}, int'(gnt), 1 << s);
        check({tag, " ring"}, int'(gnt_ring[s*2 +: 2]), ring);
        req_vld[s] = 1'b0;
    endtask

    task automatic release_ports(input logic [NP-1:0] m);
        @(negedge clk);
        rel = m;
        @(negedge clk);
        rel = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset gnt", int'(gnt), 0);
        check("R1 reset err", int'(req_err), 0);

        // R3 / R9: table walk, each transfer released before the next.
        for (int i = 0; i < 8; i++) begin
            one(TBL[i][0], TBL[i][1], TBL[i][2], "R3 R9 table");
            release_ports(NP'(1) << TBL[i][0]);
        end

        // R7: self-addressed and out-of-range destinations.
        @(negedge clk);
        ask(6, 6);
        @(negedge clk);
        check("R7 self err", int'(req_err), 1 << 6);
        check("R7 self no grant", int'(gnt), 0);
        req_dst[6*4 +: 4] = 4'd12;
        @(negedge clk);
        check("R7 range err", int'(req_err), 1 << 6);
        check("R7 range no grant", int'(gnt), 0);
        req_vld[6] = 1'b0;
        @(negedge clk);
        check("R7 err clears", int'(req_err), 0);

        // R4: overlapping upward paths force a downward placement.
        one(0, 4, 0, "R4 first");
        one(1, 3, 1, "R4 second");
        one(2, 3, 2, "R4 fallback");
        release_ports(12'b0000_0000_0111);

        // R5: six disjoint upward hops fill rings 0 and 1.
        one(0, 1, 0, "R5 fill");
        one(2, 3, 1, "R5 fill");
        one(4, 5, 0, "R5 fill");
        one(6, 7, 1, "R5 fill");
        one(8, 9, 0, "R5 fill");
        one(10, 11, 1, "R5 fill");
        one(1, 2, 3, "R5 full rings");
        release_ports(12'b0101_0101_0111);

        // R8: ports 1, 5, 9 at once; search starts after port 1 -> 5, 9, 1.
        @(negedge clk);
        ask(1, 2); ask(5, 6); ask(9, 10);
        @(negedge clk);
        check("R8 first", int'(gnt), 1 << 5);
        @(negedge clk);
        check("R8 second", int'(gnt), 1 << 9);
        @(negedge clk);
        check("R8 wrap", int'(gnt), 1 << 1);
        req_vld = '0;
        release_ports(12'b0010_0010_0010);

        // R6: held request from a busy port waits for its release.
        @(negedge clk);
        ask(4, 5);
        @(negedge clk);
        check("R6 grant", int'(gnt), 1 << 4);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R6 busy no grant", int'(gnt), 0);
        end
        rel[4] = 1'b1;
        @(negedge clk);
        rel[4] = 1'b0;
        check("R6 release cycle", int'(gnt), 0);
        @(negedge clk);
        check("R6 regrant", int'(gnt), 1 << 4);
        req_vld[4] = 1'b0;
        release_ports(NP'(1) << 4);
        @(negedge clk);
        check("R6 quiet", int'(gnt), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule